// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Sense Unit

This block detects interrupt conditions on the pins of a general-purpose port. Every clock it compares the effective input vector with the value it held one cycle earlier. The effective input vector has already had the output readback merged in. For each pin whose value changed, the block looks at the sense field of that pin's control byte. If the field selects the kind of change that just happened, the pin's bit in a sticky flag register is set. No global enable exists: a pin takes part only through its own sense field.

Software sees the flag register at two aliased bus addresses, and both return the same value. A write to either address clears every flag bit written as one. One interrupt request line goes to the processor. It rises when a new flag is recorded and falls once the flag register is empty. Vectoring, priority and wake-up are handled elsewhere.

Top module: `pin_sense_unit`

## Requirements
- R1: After a synchronous reset (rstN low for at least one clock edge), flags and irq are zero, and no flag is set on the first cycles after reset even when pinIn is nonzero and steady.
- R2: A pin whose pinIn value equals its value on the previous clock edge never has its flag set, whatever its sense field holds.
- R3: Sense code 1 sets the flag on any change of the pin, code 2 on a 0-to-1 change only, and code 3 on a 1-to-0 change only. The code is bits [2:0] of that pin's CTRL_W-bit slice of pinCtrl (pin i at bits i*CTRL_W+2 down to i*CTRL_W).
- R4: Sense code 5 (low level) sets the flag when the pin changes to 0 and never when it changes to 1.
- R5: Sense codes 0, 4, 6 and 7 never set a flag, and bits of a control slice above bit 2 have no effect on detection.
- R6: Flags are sticky. A flag bit stays set until it is cleared, and newly detected pins are ORed into the bits already set.
- R7: A write (busWrEn high) to address VIEW_A or VIEW_B clears exactly those flag bits where busWrData is 1. Bits written as 0 keep their value.
- R8: A write to any other address leaves flags and irq unchanged.
- R9: When a detection and a clearing write hit the same flag bit on the same edge, the bit ends up set.
- R10: irq becomes 1 on the edge after any flag is newly set. It stays 1 while any flag is set and becomes 0 on the edge on which the flag register becomes all zero.
- R11: rdData equals flags when busAddr is VIEW_A or VIEW_B, and is zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| pinIn | input | NUM_PINS | Effective input value of each pin |
| pinCtrl | input | NUM_PINS*CTRL_W | Control byte of every pin, pin 0 lowest; sense code in bits [2:0] of each |
| busWrEn | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus address for writes and reads |
| busWrData | input | NUM_PINS | Write data, one bit per pin (1 = clear) |
| rdData | output | NUM_PINS | Flag register as read at busAddr |
| flags | output | NUM_PINS | Current flag register |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the unit with four pins, 8-bit control slices, a 6-bit address and the two views at 0x03 and 0x29. With four pins, every pair of old and new input vectors (256 pairs) can be swept under all eight sense codes. Each sweep rotates the codes across the pins and sets junk in the upper control bits. This reaches every transition type under every code, including the steady case and the reserved codes. Directed sequences then cover the accumulation of flags, the two aliased clear views, writes to foreign addresses, set-over-clear on the same edge and the irq fall when the last flag is cleared.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;

  localparam int SENSE_W = 3;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_OFF  = 3'd0,
    SENSE_BOTH = 3'd1,
    SENSE_RISE = 3'd2,
    SENSE_FALL = 3'd3,
    SENSE_LOW  = 3'd5
  } senseMode_e;

  // Per-pin arming decoded from the sense field
  typedef struct packed {
    logic onRise;
    logic onFall;
  } pinArm_t;

  // Bus strobes from control to datapath
  typedef struct packed {
    logic addrHit;   // busAddr selects one of the flag views
    logic clrStrobe; // write-one-to-clear to a flag view
  } busStrobe_t;

endpackage

// File: rtl/pin_sense_ctrl.sv
module pin_sense_ctrl
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CTRL_W   = 8,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] VIEW_A = 6'h03,
  parameter logic [ADDR_W-1:0] VIEW_B = 6'h29
) (
  input  logic                       busWrEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NUM_PINS*CTRL_W-1:0] pinCtrl,
  output pinArm_t [NUM_PINS-1:0]     arm,
  output busStrobe_t                 strobe
);

  always_comb begin
    strobe.addrHit   = (busAddr == VIEW_A) || (busAddr == VIEW_B);
    strobe.clrStrobe = busWrEn && strobe.addrHit;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPinDecode
    logic [SENSE_W-1:0] senseField;
    assign senseField = pinCtrl[g*CTRL_W +: SENSE_W];

    always_comb begin
      arm[g] = '0;
      unique case (senseField)
        SENSE_BOTH: begin arm[g].onRise = 1'b1; arm[g].onFall = 1'b1; end
        SENSE_RISE: arm[g].onRise = 1'b1;
        SENSE_FALL: arm[g].onFall = 1'b1;
        SENSE_LOW:  arm[g].onFall = 1'b1;
        default:    arm[g] = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_sense_dp.sv
module pin_sense_dp
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PINS-1:0]    pinIn,
  input  pinArm_t [NUM_PINS-1:0] arm,
  input  busStrobe_t             strobe,
  input  logic [NUM_PINS-1:0]    busWrData,
  output logic [NUM_PINS-1:0]    flags,
  output logic [NUM_PINS-1:0]    rdData,
  output logic                   irq
);

  logic [NUM_PINS-1:0] prevIn;
  logic [NUM_PINS-1:0] roseNow;
  logic [NUM_PINS-1:0] fellNow;
  logic [NUM_PINS-1:0] hits;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] flagsNext;
  logic                irqNext;

  assign roseNow = pinIn & ~prevIn;
  assign fellNow = ~pinIn & prevIn;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gHit
    assign hits[g] = (arm[g].onRise & roseNow[g]) | (arm[g].onFall & fellNow[g]);
  end

  always_comb begin
    clrMask   = strobe.clrStrobe ? busWrData : '0;
    flagsNext = (flags & ~clrMask) | hits;
    if (|hits)               irqNext = 1'b1;
    else if (flagsNext == '0) irqNext = 1'b0;
    else                      irqNext = irq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= pinIn;
      flags  <= '0;
      irq    <= 1'b0;
    end else begin
      prevIn <= pinIn;
      flags  <= flagsNext;
      irq    <= irqNext;
    end
  end

  assign rdData = strobe.addrHit ? flags : '0;

endmodule

// File: rtl/pin_sense_unit.sv
module pin_sense_unit
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CTRL_W   = 8,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] VIEW_A = 6'h03,
  parameter logic [ADDR_W-1:0] VIEW_B = 6'h29
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS*CTRL_W-1:0] pinCtrl,
  input  logic                       busWrEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NUM_PINS-1:0]        busWrData,
  output logic [NUM_PINS-1:0]        rdData,
  output logic [NUM_PINS-1:0]        flags,
  output logic                       irq
);

  pinArm_t [NUM_PINS-1:0] arm;
  busStrobe_t             strobe;

  pin_sense_ctrl #(
    .NUM_PINS(NUM_PINS), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W),
    .VIEW_A(VIEW_A), .VIEW_B(VIEW_B)
  ) uCtrl (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .pinCtrl(pinCtrl),
    .arm(arm),
    .strobe(strobe)
  );

  pin_sense_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk(clk),
    .rstN(rstN),
    .pinIn(pinIn),
    .arm(arm),
    .strobe(strobe),
    .busWrData(busWrData),
    .flags(flags),
    .rdData(rdData),
    .irq(irq)
  );

endmodule

// File: rtl/pin_sense_chk.sv
module pin_sense_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] VIEW_A = 6'h03,
  parameter logic [ADDR_W-1:0] VIEW_B = 6'h29
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [NUM_PINS-1:0] busWrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic [NUM_PINS-1:0] flags,
  input logic                irq
);

  // R10: request line follows flag occupancy
  p_irq_tracks_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (flags != '0));

  // R2: steady inputs and no write leave flags untouched
  p_steady_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && $stable(pinIn)) |=> $stable(flags));

  // R6: without a write no flag bit ever drops
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ((flags & $past(flags)) == $past(flags)));

  // R7: a clearing write with steady inputs empties the written bits
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == VIEW_A || busAddr == VIEW_B) && $stable(pinIn))
      |=> ((flags & $past(busWrData)) == '0));

  // R8: foreign writes with steady inputs change nothing
  p_foreign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != VIEW_A && busAddr != VIEW_B && $stable(pinIn))
      |=> $stable(flags));

  // R11: non-view addresses read as zero
  p_rd_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != VIEW_A && busAddr != VIEW_B) |-> (rdData == '0));

endmodule

bind pin_sense_unit pin_sense_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .VIEW_A(VIEW_A), .VIEW_B(VIEW_B)
) uChk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn),
  .busAddr(busAddr), .busWrData(busWrData), .rdData(rdData),
  .flags(flags), .irq(irq)
);

// File: tb/pin_sense_unit_test.sv
module pin_sense_unit_test;

  localparam int NP = 4;
  localparam int CW = 8;
  localparam int AW = 6;
  localparam logic [AW-1:0] VA = 6'h03;
  localparam logic [AW-1:0] VB = 6'h29;
  localparam logic [AW-1:0] VX = 6'h04;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NP-1:0]  pinIn = '0;
  logic [NP*CW-1:0] pinCtrl = '0;
  logic           busWrEn = 1'b0;
  logic [AW-1:0]  busAddr = '0;
  logic [NP-1:0]  busWrData = '0;
  logic [NP-1:0]  rdData;
  logic [NP-1:0]  flags;
  logic           irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pin_sense_unit #(
    .NUM_PINS(NP), .CTRL_W(CW), .ADDR_W(AW), .VIEW_A(VA), .VIEW_B(VB)
  ) uut (.*);

  function automatic logic senseHit(int mode, logic o, logic n);
    case (mode)
      1: return o != n;
      2: return !o && n;
      3: return o && !n;
      5: return o && !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setAllModes(int mode);
    for (int i = 0; i < NP; i++) pinCtrl[i*CW +: CW] = 8'(mode);
  endtask

  task automatic clearAll();
    busWrEn = 1'b1; busAddr = VA; busWrData = '1;
    tick();
    busWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, no spurious edge with steady nonzero input
    setAllModes(1);
    pinIn = 4'b1010;
    repeat (3) tick();
    rstN = 1'b1;
    tick(); tick();
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);

    // R2 R3 R4 R5 R10 R11: exhaustive sweep of transitions per mode
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < NP; i++)
        pinCtrl[i*CW +: CW] = 8'hA8 | 8'((m + i) % 8);
      for (int p = 0; p < 16; p++) begin
        for (int n = 0; n < 16; n++) begin
          logic [NP-1:0] expF;
          expF = '0;
          for (int i = 0; i < NP; i++)
            expF[i] = senseHit((m + i) % 8, p[i], n[i]);
          pinIn = NP'(p);
          tick();
          clearAll();
          busAddr = VB;
          pinIn = NP'(n);
          tick();
          if (p == n) check("R2 steady", flags, 0);
          else        check("R3 R4 R5 sense", flags, expF);
          check("R10 irq", irq, (expF != 0));
          check("R11 view B read", rdData, expF);
        end
      end
    end

    // R6: accumulation
    setAllModes(1);
    pinIn = '0; tick(); clearAll();
    pinIn = 4'b0001; tick(); tick();
    pinIn = 4'b0101; tick(); tick();
    check("R6 accumulate", flags, 4'b0101);

    // R11: both views identical, foreign zero
    busAddr = VA; #1; check("R11 view A", rdData, 4'b0101);
    busAddr = VB; #1; check("R11 view B", rdData, 4'b0101);
    busAddr = VX; #1; check("R11 foreign", rdData, 0);

    // R7: clear through view A then view B, zero bits untouched
    busWrEn = 1'b1; busAddr = VA; busWrData = 4'b0001; tick(); busWrEn = 1'b0;
    check("R7 clear A", flags, 4'b0100);
    check("R10 still high", irq, 1);
    busWrEn = 1'b1; busAddr = VB; busWrData = 4'b0100; tick(); busWrEn = 1'b0;
    check("R7 clear B", flags, 0);
    check("R10 drop", irq, 0);

    // R8: foreign-address write ignored
    pinIn = 4'b0111; tick(); tick();
    busWrEn = 1'b1; busAddr = VX; busWrData = '1; tick(); busWrEn = 1'b0;
    check("R8 foreign flags", flags, 4'b0010);
    check("R8 foreign irq", irq, 1);

    // R9: set wins over simultaneous clear
    clearAll();
    busWrEn = 1'b1; busAddr = VA; busWrData = 4'b1000; pinIn = 4'b1111;
    tick(); busWrEn = 1'b0;
    check("R9 set wins", flags, 4'b1000);
    check("R9 irq", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule